// File: doc/BRIEF.md
# Remote Terminal Command Legality Checker and Descriptor Address Generator

This block sits in a remote terminal after the command word decoder. Each time a command word arrives it sorts the command into one of eight classes. Three things set the class: whether the command is a mode code or a plain subaddress transfer, whether it is broadcast, and whether the terminal is asked to transmit or receive. The block then looks up one illegal bit for that class and for the subaddress or mode code number. Some combinations are forbidden by the protocol itself, and those are flagged without any register lookup.

A legal command produces the local memory address of its four-word descriptor (control, top pointer, current pointer, message information pointer). The DMA engine that follows uses this address for its burst fetch. An illegal command raises a message-error pulse instead, and no address strobe is issued. The host sets the illegal bitmap and the descriptor base through a small register write port.

Top module: `rt_cmd_legalizer`

## Requirements
- R1: The result appears in the cycle after `cmd_valid`. `cmd_class` is {mode, broadcast, transmit}: bit 2 is mode code, bit 1 is broadcast, bit 0 is transmit. The command word layout is: bits 15:11 RT address, bit 10 transmit (1) or receive (0), bits 9:5 subaddress, bits 4:0 word count or mode code.
- R2: A subaddress field of 0 or 31 marks a mode code command, and bits 4:0 then give the mode code number. For a mode code, `mode_data` equals bit 4 of the command word. For any other command `mode_data` is 0.
- R3: A command is broadcast when `cmd_bcast` is high or when the RT address field is 31.
- R4: The descriptor address is base + 0x80·{mode, transmit} + 4·index. The index is the mode code number for a mode code command and the subaddress otherwise. Examples with base 0x1100: receive SA1 gives 0x1104, transmit SA2 gives 0x1188, receive mode code 1 gives 0x1204.
- R5: The illegal registers sit at host addresses 0–15. Register number 2·class + index[4] holds the bit for this command, with class = {mode, broadcast, transmit}. Bit index[3:0] of that register is the illegal flag, and a 1 means illegal. The class order is therefore: receive, transmit, broadcast receive, broadcast transmit, mode receive, mode transmit, broadcast mode receive, broadcast mode transmit.
- R6: A broadcast transmit command that is not a mode code is always illegal.
- R7: A broadcast transmit mode code numbered 16–31 is always illegal, whatever the registers hold.
- R8: Every command produces exactly one pulse in the following cycle: `desc_valid` if legal or `msg_error` if illegal. With no command, neither pulse occurs.
- R9: A write to host address 16 loads the descriptor base. Writes to addresses 17–31 change nothing. A command in the same cycle as a write sees the old register contents.
- R10: After reset all illegal bits and the base are zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Decoded command word |
| cmd_bcast | input | 1 | Broadcast flag from the decoder |
| host_we | input | 1 | Host register write enable |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 16 | Host write data |
| desc_valid | output | 1 | Legal command, descriptor address valid |
| desc_addr | output | 16 | Descriptor address |
| msg_error | output | 1 | Illegal command pulse |
| cmd_class | output | 3 | {mode, broadcast, transmit} |
| mode_data | output | 1 | Mode code carries a data word |

## Verification
The hardest case to reach from the ports is a broadcast transmit mode code in the upper half (16–31) while its register bit is clear. Only the fixed protocol rule can then flag it, so a broken rule stays hidden unless the bitmap is zero at that point. The bench issues this command directly after reset, while the registers are all zero, and then once more with the neighbouring mode code 1, which must stay legal. Random traffic then mixes host writes with commands in the same cycle, and a behavioural model checks every cycle.

// File: rtl/rt_legal_pkg.sv
package rt_legal_pkg;

   localparam int CMD_W       = 16;
   localparam int FIELD_W     = 5;
   localparam int NUM_CLASSES = 8;
   localparam logic [FIELD_W-1:0] BCAST_RT  = 5'd31;
   localparam logic [FIELD_W-1:0] MC_SA_LO  = 5'd0;
   localparam logic [FIELD_W-1:0] MC_SA_HI  = 5'd31;

   typedef struct packed {
      logic [FIELD_W-1:0] rt;
      logic               tx;
      logic [FIELD_W-1:0] sa;
      logic [FIELD_W-1:0] wc;
   } cmd_fields_t;

   typedef struct packed {
      logic mode;
      logic bcast;
      logic tx;
   } cmd_class_t;

   function automatic logic is_mode_sa(input logic [FIELD_W-1:0] sa);
      return (sa == MC_SA_LO) || (sa == MC_SA_HI);
   endfunction

endpackage

// File: rtl/rt_cmd_classify.sv
module rt_cmd_classify
   import rt_legal_pkg::*;
(
   input  logic [CMD_W-1:0]   cmd_word,
   input  logic               bcast_in,
   output cmd_class_t         cls,
   output logic [FIELD_W-1:0] idx,
   output logic               has_data
);
   cmd_fields_t f;
   logic        mode_c;

   always_comb begin
      f         = cmd_fields_t'(cmd_word);
      mode_c    = is_mode_sa(f.sa);
      cls.mode  = mode_c;
      cls.bcast = bcast_in | (f.rt == BCAST_RT);
      cls.tx    = f.tx;
      idx       = mode_c ? f.wc : f.sa;
      has_data  = mode_c & f.wc[FIELD_W-1];
   end
endmodule

// File: rtl/rt_illegal_bank.sv
module rt_illegal_bank
   import rt_legal_pkg::*;
#(
   parameter int BANK_W  = 16,
   parameter int HADDR_W = 5,
   parameter int HDATA_W = 16,
   parameter int ADDR_W  = 16
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [HADDR_W-1:0] waddr,
   input  logic [HDATA_W-1:0] wdata,
   input  cmd_class_t         cls,
   input  logic [FIELD_W-1:0] idx,
   output logic               ill_bit,
   output logic [ADDR_W-1:0]  base
);
   localparam int SA_COUNT  = 1 << FIELD_W;
   localparam int REGS_PER  = SA_COUNT / BANK_W;
   localparam int NUM_REGS  = NUM_CLASSES * REGS_PER;
   localparam int BIT_W     = $clog2(BANK_W);
   localparam int SEL_W     = FIELD_W - BIT_W;
   localparam int FLAT_W    = NUM_REGS * BANK_W;
   localparam int FLAT_IW   = $clog2(FLAT_W);
   localparam int BASE_SLOT = NUM_REGS;

   if (BANK_W != 8 && BANK_W != 16) begin : g_bad_bank
      $error("BANK_W must be 8 or 16");
   end
   if (BANK_W > HDATA_W) begin : g_bad_hdata
      $error("BANK_W wider than host data");
   end
   if (ADDR_W > HDATA_W) begin : g_bad_addr
      $error("ADDR_W wider than host data");
   end
   if (BASE_SLOT >= (1 << HADDR_W)) begin : g_bad_map
      $error("host address space too small for register map");
   end

   logic [FLAT_W-1:0] ill_flat;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [BANK_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (we && waddr == HADDR_W'(i))
            q <= wdata[BANK_W-1:0];
      end
      assign ill_flat[i*BANK_W +: BANK_W] = q;
   end

   logic [ADDR_W-1:0] base_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         base_q <= '0;
      else if (we && waddr == HADDR_W'(BASE_SLOT))
         base_q <= wdata[ADDR_W-1:0];
   end
   assign base = base_q;

   logic [SEL_W-1:0]   hi_sel;
   logic [FLAT_IW-1:0] flat_idx;
   always_comb begin
      hi_sel   = idx[FIELD_W-1 -: SEL_W];
      flat_idx = {cls, hi_sel, idx[BIT_W-1:0]};
      ill_bit  = ill_flat[flat_idx];
   end
endmodule

// File: rtl/rt_rule_check.sv
module rt_rule_check
   import rt_legal_pkg::*;
#(
   parameter bit STRICT_B = 1'b1
)(
   input  cmd_class_t         cls,
   input  logic [FIELD_W-1:0] idx,
   input  logic               ill_bit,
   output logic               illegal
);
   logic bc_tx_data;
   logic bc_tx_mc;

   always_comb bc_tx_data = cls.bcast & cls.tx & ~cls.mode;

   if (STRICT_B) begin : g_strict
      always_comb bc_tx_mc = cls.bcast & cls.tx & cls.mode & idx[FIELD_W-1];
   end else begin : g_loose
      always_comb bc_tx_mc = 1'b0;
   end

   always_comb illegal = ill_bit | bc_tx_data | bc_tx_mc;
endmodule

// File: rtl/rt_desc_addr_gen.sv
module rt_desc_addr_gen
   import rt_legal_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DESC_WORDS   = 4,
   parameter int CLASS_STRIDE = 128
)(
   input  logic [ADDR_W-1:0]  base,
   input  cmd_class_t         cls,
   input  logic [FIELD_W-1:0] idx,
   output logic [ADDR_W-1:0]  addr
);
   localparam int DW_SHIFT  = $clog2(DESC_WORDS);
   localparam int CS_SHIFT  = $clog2(CLASS_STRIDE);
   localparam bit CS_POW2   = ((1 << CS_SHIFT) == CLASS_STRIDE);

   if ((1 << DW_SHIFT) != DESC_WORDS) begin : g_bad_dw
      $error("DESC_WORDS must be a power of two");
   end
   if (CLASS_STRIDE < (DESC_WORDS << FIELD_W)) begin : g_bad_stride
      $error("CLASS_STRIDE overlaps adjacent descriptor classes");
   end

   logic [1:0]        grp;
   logic [ADDR_W-1:0] grp_off;
   logic [ADDR_W-1:0] ent_off;

   always_comb grp = {cls.mode, cls.tx};

   if (CS_POW2) begin : g_shift
      always_comb grp_off = ADDR_W'(grp) << CS_SHIFT;
   end else begin : g_mult
      always_comb grp_off = ADDR_W'(grp) * ADDR_W'(CLASS_STRIDE);
   end

   always_comb begin
      ent_off = ADDR_W'(idx) << DW_SHIFT;
      addr    = base + grp_off + ent_off;
   end
endmodule

// File: rtl/rt_cmd_legalizer.sv
module rt_cmd_legalizer
   import rt_legal_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int HADDR_W      = 5,
   parameter int HDATA_W      = 16,
   parameter int BANK_W       = 16,
   parameter int DESC_WORDS   = 4,
   parameter int CLASS_STRIDE = 128,
   parameter bit STRICT_B     = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [15:0]        cmd_word,
   input  logic               cmd_bcast,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [HDATA_W-1:0] host_wdata,
   output logic               desc_valid,
   output logic [ADDR_W-1:0]  desc_addr,
   output logic               msg_error,
   output logic [2:0]         cmd_class,
   output logic               mode_data
);
   cmd_class_t         cls;
   logic [FIELD_W-1:0] idx;
   logic               has_data;
   logic               ill_bit;
   logic               illegal;
   logic [ADDR_W-1:0]  base;
   logic [ADDR_W-1:0]  addr_c;

   rt_cmd_classify u_cls (
      .cmd_word (cmd_word),
      .bcast_in (cmd_bcast),
      .cls      (cls),
      .idx      (idx),
      .has_data (has_data)
   );

   rt_illegal_bank #(
      .BANK_W  (BANK_W),
      .HADDR_W (HADDR_W),
      .HDATA_W (HDATA_W),
      .ADDR_W  (ADDR_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (host_we),
      .waddr   (host_addr),
      .wdata   (host_wdata),
      .cls     (cls),
      .idx     (idx),
      .ill_bit (ill_bit),
      .base    (base)
   );

   rt_rule_check #(
      .STRICT_B (STRICT_B)
   ) u_rule (
      .cls     (cls),
      .idx     (idx),
      .ill_bit (ill_bit),
      .illegal (illegal)
   );

   rt_desc_addr_gen #(
      .ADDR_W       (ADDR_W),
      .DESC_WORDS   (DESC_WORDS),
      .CLASS_STRIDE (CLASS_STRIDE)
   ) u_addr (
      .base (base),
      .cls  (cls),
      .idx  (idx),
      .addr (addr_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         desc_valid <= 1'b0;
         msg_error  <= 1'b0;
         desc_addr  <= '0;
         cmd_class  <= '0;
         mode_data  <= 1'b0;
      end else begin
         desc_valid <= cmd_valid & ~illegal;
         msg_error  <= cmd_valid & illegal;
         if (cmd_valid) begin
            desc_addr <= addr_c;
            cmd_class <= cls;
            mode_data <= has_data;
         end
      end
   end
endmodule

// File: rtl/rt_cmd_legalizer_chk.sv
module rt_cmd_legalizer_chk #(
   parameter bit STRICT_B = 1'b1
)(
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic [15:0] cmd_word,
   input logic        cmd_bcast,
   input logic        desc_valid,
   input logic        msg_error,
   input logic        mode_data
);
   logic in_mode;
   logic in_bc;
   assign in_mode = (cmd_word[9:5] == 5'd0) || (cmd_word[9:5] == 5'd31);
   assign in_bc   = cmd_bcast || (cmd_word[15:11] == 5'd31);

   // R8
   resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(desc_valid && msg_error));

   // R8
   resp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (desc_valid || msg_error));

   // R8
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> (!desc_valid && !msg_error));

   // R6
   bc_tx_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && in_bc && cmd_word[10] && !in_mode) |=> msg_error);

   // R7
   bc_tx_mc_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (STRICT_B && cmd_valid && in_bc && cmd_word[10] && in_mode && cmd_word[4]) |=> msg_error);

   // R2
   plain_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !in_mode) |=> !mode_data);
endmodule

bind rt_cmd_legalizer rt_cmd_legalizer_chk #(.STRICT_B(STRICT_B)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_word   (cmd_word),
   .cmd_bcast  (cmd_bcast),
   .desc_valid (desc_valid),
   .msg_error  (msg_error),
   .mode_data  (mode_data)
);

// File: tb/rt_cmd_legalizer_tb.sv
module rt_cmd_legalizer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_word = '0;
   logic        cmd_bcast = 1'b0;
   logic        host_we = 1'b0;
   logic [4:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        desc_valid;
   logic [15:0] desc_addr;
   logic        msg_error;
   logic [2:0]  cmd_class;
   logic        mode_data;

   always #2 clk = ~clk;

   rt_cmd_legalizer u_dut (
      .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_word (cmd_word),
      .cmd_bcast (cmd_bcast), .host_we (host_we), .host_addr (host_addr),
      .host_wdata (host_wdata), .desc_valid (desc_valid), .desc_addr (desc_addr),
      .msg_error (msg_error), .cmd_class (cmd_class), .mode_data (mode_data)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // behavioural model state
   int m_ill [16];
   int m_base = 0;
   int e_valid = 0, e_err = 0, e_addr = 0, e_cls = 0, e_md = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R8 desc_valid", desc_valid, e_valid);
      chk("R5 msg_error", msg_error, e_err);
      chk("R4 desc_addr", desc_addr, e_addr);
      chk("R1 cmd_class", cmd_class, e_cls);
      chk("R2 mode_data", mode_data, e_md);
   endtask

   task automatic model(int cv, int w, int b, int we, int wa, int wd);
      int rt, tx, sa, wc, md, bc, ix, cl, il;
      e_valid = 0;
      e_err   = 0;
      if (cv != 0) begin
         rt = (w >> 11) & 31; tx = (w >> 10) & 1;
         sa = (w >> 5) & 31;  wc = w & 31;
         md = (sa == 0 || sa == 31) ? 1 : 0;
         bc = (b != 0 || rt == 31) ? 1 : 0;
         ix = md ? wc : sa;
         cl = md * 4 + bc * 2 + tx;
         il = (m_ill[cl * 2 + ix / 16] >> (ix % 16)) & 1;
         if (bc == 1 && tx == 1 && md == 0) il = 1;
         if (bc == 1 && tx == 1 && md == 1 && ix >= 16) il = 1;
         e_valid = il ? 0 : 1;
         e_err   = il;
         e_addr  = (m_base + (md * 2 + tx) * 128 + ix * 4) & 16'hFFFF;
         e_cls   = cl;
         e_md    = (md == 1 && wc >= 16) ? 1 : 0;
      end
      if (we != 0) begin
         if (wa < 16) m_ill[wa] = wd & 16'hFFFF;
         else if (wa == 16) m_base = wd & 16'hFFFF;
      end
   endtask

   task automatic apply(int cv, int w, int b, int we, int wa, int wd);
      @(negedge clk);
      compare();
      cmd_valid  = cv[0];
      cmd_word   = w[15:0];
      cmd_bcast  = b[0];
      host_we    = we[0];
      host_addr  = wa[4:0];
      host_wdata = wd[15:0];
      model(cv, w, b, we, wa, wd);
   endtask

   task automatic idle();
      apply(0, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(int a, int d);
      apply(0, 0, 0, 1, a, d);
   endtask

   task automatic cmd_chk(string tag, int w, int b, int exp_err, int exp_addr);
      apply(1, w, b, 0, 0, 0);
      idle();
      chk(tag, msg_error, exp_err);
      chk(tag, desc_valid, exp_err ? 0 : 1);
      if (!exp_err) chk(tag, desc_addr, exp_addr);
   endtask

   initial begin
      #800000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_ill[i] = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 desc_valid", desc_valid, 0);
      chk("R10 msg_error", msg_error, 0);
      chk("R10 desc_addr", desc_addr, 0);
      chk("R10 cmd_class", cmd_class, 0);
      // R7 with empty bitmap: bcast tx mode code 17 illegal, mode code 1 legal
      cmd_chk("R7", 16'h2FF1, 1, 1, 0);
      cmd_chk("R7", 16'h2FE1, 1, 0, 16'h0184);
      // R9 base load
      wr(16, 16'h1100);
      cmd_chk("R4", 16'h2822, 0, 0, 16'h1104);
      cmd_chk("R4", 16'h2C44, 0, 0, 16'h1188);
      cmd_chk("R4", 16'h2801, 0, 0, 16'h1204);
      chk("R1", cmd_class, 3'b100);
      chk("R2", mode_data, 0);
      cmd_chk("R2", 16'h2FF1, 0, 0, 16'h12C4);
      chk("R1", cmd_class, 3'b101);
      chk("R2", mode_data, 1);
      // R5 lower and upper half registers
      wr(2, 16'h0004);
      cmd_chk("R5", 16'h2C44, 0, 1, 0);
      wr(1, 16'h0010);
      cmd_chk("R5", 16'h2A81, 0, 1, 0);
      // R6 broadcast via RT 31
      cmd_chk("R6", 16'hFC62, 0, 1, 0);
      chk("R3", cmd_class, 3'b011);
      // R3 broadcast via flag
      cmd_chk("R3", 16'h2822, 1, 0, 16'h1104);
      chk("R3", cmd_class, 3'b010);
      // R9 unmapped address ignored
      wr(20, 16'hFFFF);
      wr(31, 16'h0000);
      cmd_chk("R9", 16'h2822, 0, 0, 16'h1104);
      // R8 idle produces nothing
      idle();
      chk("R8", desc_valid | msg_error, 0);
      // random traffic with concurrent writes
      for (int n = 0; n < 4000; n++) begin
         int cv, w, b, we, wa, wd;
         cv = ($urandom % 3 != 0) ? 1 : 0;
         w  = $urandom & 16'hFFFF;
         b  = ($urandom % 4 == 0) ? 1 : 0;
         we = ($urandom % 5 == 0) ? 1 : 0;
         wa = $urandom % 20;
         wd = $urandom & $urandom & 16'hFFFF;
         apply(cv, w, b, we, wa, wd);
      end
      idle();
      idle();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule